// File: doc/BRIEF.md
# Handshaked Command Byte Receiver

This block takes command messages from a host one byte at a time over an 8-bit data port. Each byte moves under its own four-phase request/acknowledge handshake. The host raises SYN with a byte on the data lines. The receiver captures the byte and raises ACK. The host then drops SYN, and the receiver drops ACK before it will accept another byte. Captured bytes go into a small command buffer in arrival order, and a byte count tracks how many slots are filled.

Messages are framed by a marker value, not by a fixed length. When the end-of-command byte (0xAA) is captured, the receiver sends a one-cycle command-ready strobe to the downstream parser. It then holds the buffer still and ignores the host until the parser pulses its release input. The receiver does not check the start marker (0x55) or the message length; the parser does. Valid messages are 3, 5 or 9 bytes long, counting both markers. Bytes that arrive after the buffer is full are acknowledged but dropped, and an overflow flag is raised alongside the message.

The state machine has four states:
- WAIT_SYN: idle, ready for a byte.
- ACK_BYTE: ACK is high for an ordinary byte.
- ACK_LAST: ACK is high for the end-of-command byte.
- HOLD_MSG: the message is waiting for the parser.

It has six transitions:
- WAIT_SYN to ACK_BYTE: SYN is seen with a byte that is not the end marker.
- WAIT_SYN to ACK_LAST: SYN is seen with the end marker.
- ACK_BYTE to WAIT_SYN: SYN is low.
- ACK_LAST to HOLD_MSG: SYN is low.
- HOLD_MSG to WAIT_SYN: release is high.
- Reset: from any state to WAIT_SYN.

Top module: `cmd_byte_receiver`

## Requirements
- R1: A synchronous active-high reset leaves ACK low, the byte count at 0, the overflow flag low and command-ready low.
- R2: In WAIT_SYN, a clock edge that sees SYN high captures the data byte and raises ACK on that same edge. If the count is below the buffer depth, the byte is stored in the slot equal to the current count and the count increments.
- R3: ACK stays high for as long as SYN stays high, and no further byte is captured during that time. ACK falls on the first edge that sees SYN low.
- R4: Capturing the byte 0xAA raises command-ready for exactly one cycle, starting on the same edge as ACK.
- R5: No other byte value raises command-ready. This includes 0x55, which is stored like any data byte because the start marker is not checked.
- R6: After the end-marker handshake completes, SYN is ignored: ACK stays low and the count and buffer stay unchanged until release is seen.
- R7: Release seen in HOLD_MSG clears the count and the overflow flag on that edge. The next byte is then stored in slot 0.
- R8: A byte that arrives when the count equals the buffer depth (9 by default) is acknowledged but not stored. The count stays at the depth and the overflow flag goes high. An end marker arriving in that condition still raises command-ready.
- R9: Slot i of the buffer appears on buf_data bits [8*i+7 : 8*i]. Slot 0 holds the first byte of the message.
- R10: Release has no effect in any state other than HOLD_MSG.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_data | input | 8 | Byte offered by the host |
| host_syn | input | 1 | Host request: a byte is valid |
| host_ack | output | 1 | Receiver acknowledge |
| buf_data | output | 72 | Command buffer contents, slot i at bits 8*i+7:8*i |
| byte_count | output | 4 | Number of stored bytes |
| overflow | output | 1 | A byte was dropped because the buffer was full |
| cmd_ready | output | 1 | One-cycle strobe: a complete message is waiting |
| cmd_release | input | 1 | Parser release: clears the message and resumes reception |

## Verification
ACK, command-ready, the byte count and the stored byte all change on the first clock edge that sees SYN high in WAIT_SYN. ACK falls on the first edge that sees SYN low, and a release in HOLD_MSG clears the count on the edge that sees it. The bench drives inputs on the falling edge and reads outputs on the following falling edge, so every result is checked exactly one clock edge after its cause. Holding SYN high for extra cycles and sending SYN during HOLD_MSG are checked on every cycle in between, to confirm that nothing changes there.

// File: rtl/rx_cmd_pkg.sv
package rx_cmd_pkg;

    typedef enum logic [1:0] {
        WAIT_SYN = 2'd0,
        ACK_BYTE = 2'd1,
        ACK_LAST = 2'd2,
        HOLD_MSG = 2'd3
    } rx_state_t;

endpackage

// File: rtl/rx_hs_fsm.sv
module rx_hs_fsm
    import rx_cmd_pkg::*;
#(
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  EOC_BYTE = 8'hAA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              syn,
    input  logic [DATA_W-1:0] data,
    input  logic              release_in,
    output logic              ack,
    output logic              capture,
    output logic              clear,
    output logic              ready,
    output logic              holding
);

    rx_state_t state_q, state_d;
    logic      is_eoc;
    logic      ready_q;

    assign is_eoc = (data == DATA_W'(EOC_BYTE));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WAIT_SYN: if (syn)        state_d = is_eoc ? ACK_LAST : ACK_BYTE;
            ACK_BYTE: if (!syn)       state_d = WAIT_SYN;
            ACK_LAST: if (!syn)       state_d = HOLD_MSG;
            HOLD_MSG: if (release_in) state_d = WAIT_SYN;
            default:                  state_d = WAIT_SYN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WAIT_SYN;
            ready_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ready_q <= (state_q == WAIT_SYN) && syn && is_eoc;
        end
    end

    always_comb begin
        ack     = (state_q == ACK_BYTE) || (state_q == ACK_LAST);
        capture = (state_q == WAIT_SYN) && syn;
        clear   = (state_q == HOLD_MSG) && release_in;
        holding = (state_q == HOLD_MSG);
        ready   = ready_q;
    end

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready); // R4
    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ack && syn) |=> ack); // R3
    AST_NO_CAPTURE_IN_ACK: assert property (@(posedge clk) disable iff (rst)
        ack |-> !capture); // R3
    AST_HOLD_IGNORES_SYN: assert property (@(posedge clk) disable iff (rst)
        (holding && !release_in) |=> (holding && !ack)); // R6

endmodule

// File: rtl/rx_cmd_buffer.sv
module rx_cmd_buffer #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 9,
    parameter int CNT_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic                    clr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [DEPTH*DATA_W-1:0] slots,
    output logic [CNT_W-1:0]        count,
    output logic                    overflow
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic room;
    assign room = (count < FULL);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DATA_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= '0;
            else if (wr_en && (count == CNT_W'(g)))
                slot_q <= wr_data;
        end
        assign slots[g*DATA_W +: DATA_W] = slot_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count    <= '0;
            overflow <= 1'b0;
        end else if (wr_en) begin
            if (room)
                count <= count + 1'b1;
            else
                overflow <= 1'b1;
        end
    end

    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (rst)
        count <= FULL); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !room) |=> (overflow && count == FULL)); // R8
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0 && !overflow)); // R7

endmodule

// File: rtl/cmd_byte_receiver.sv
module cmd_byte_receiver #(
    parameter int         DATA_W   = 8,
    parameter int         DEPTH    = 9,
    parameter logic [7:0] EOC_BYTE = 8'hAA,
    localparam int        CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [DATA_W-1:0]       host_data,
    input  logic                    host_syn,
    output logic                    host_ack,
    output logic [DEPTH*DATA_W-1:0] buf_data,
    output logic [CNT_W-1:0]        byte_count,
    output logic                    overflow,
    output logic                    cmd_ready,
    input  logic                    cmd_release
);

    logic capture, clear, holding;

    rx_hs_fsm #(
        .DATA_W   (DATA_W),
        .EOC_BYTE (EOC_BYTE)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .syn        (host_syn),
        .data       (host_data),
        .release_in (cmd_release),
        .ack        (host_ack),
        .capture    (capture),
        .clear      (clear),
        .ready      (cmd_ready),
        .holding    (holding)
    );

    rx_cmd_buffer #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .CNT_W  (CNT_W)
    ) u_buf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (capture),
        .clr      (clear),
        .wr_data  (host_data),
        .slots    (buf_data),
        .count    (byte_count),
        .overflow (overflow)
    );

    AST_ACK_NEEDS_SYN: assert property (@(posedge clk) disable iff (rst)
        $rose(host_ack) |-> $past(host_syn)); // R2
    AST_READY_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> $rose(host_ack)); // R4
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (holding && !cmd_release) |=> ($stable(byte_count) && $stable(buf_data))); // R6
    AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!holding && cmd_release && !host_syn) |=> $stable(byte_count)); // R10

endmodule

// File: tb/sim_cmd_byte_receiver.sv
module sim_cmd_byte_receiver;

    localparam int DEPTH = 9;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [7:0]         host_data = '0;
    logic               host_syn = 1'b0;
    logic               host_ack;
    logic [DEPTH*8-1:0] buf_data;
    logic [CNT_W-1:0]   byte_count;
    logic               overflow;
    logic               cmd_ready;
    logic               cmd_release = 1'b0;

    int errors = 0;
    int checks = 0;

    logic [7:0] exp_buf [DEPTH];
    int         exp_cnt = 0;
    bit         exp_ovf = 1'b0;

    always #5 clk = ~clk;

    cmd_byte_receiver u0 (
        .clk         (clk),
        .rst         (rst),
        .host_data   (host_data),
        .host_syn    (host_syn),
        .host_ack    (host_ack),
        .buf_data    (buf_data),
        .byte_count  (byte_count),
        .overflow    (overflow),
        .cmd_ready   (cmd_ready),
        .cmd_release (cmd_release)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] rand_payload();
        logic [7:0] b = 8'($urandom);
        if (b == 8'hAA) b = 8'h3C;
        return b;
    endfunction

    function automatic int model_next_cnt(input int c);
        return (c < DEPTH) ? c + 1 : c;
    endfunction

    // send one byte; extra = cycles SYN stays high after ACK is seen
    task automatic send_byte(input logic [7:0] b, input int extra);
        int  prev = exp_cnt;
        bit  eoc  = (b == 8'hAA);
        host_data = b;
        host_syn  = 1'b1;
        @(negedge clk);
        chk(host_ack == 1'b1, "R2 ack rises", int'(host_ack), 1);
        if (prev < DEPTH) exp_buf[prev] = b; else exp_ovf = 1'b1;
        exp_cnt = model_next_cnt(prev);
        chk(int'(byte_count) == exp_cnt, "R2 count", int'(byte_count), exp_cnt);
        if (prev < DEPTH)
            chk(buf_data[8*prev +: 8] == b, "R9 slot", int'(buf_data[8*prev +: 8]), int'(b));
        else
            chk(overflow == 1'b1, "R8 overflow", int'(overflow), 1);
        if (eoc) chk(cmd_ready == 1'b1, "R4 ready", int'(cmd_ready), 1);
        else     chk(cmd_ready == 1'b0, "R5 no ready", int'(cmd_ready), 0);
        for (int k = 0; k < extra; k++) begin
            @(negedge clk);
            chk(host_ack == 1'b1, "R3 ack held", int'(host_ack), 1);
            chk(int'(byte_count) == exp_cnt, "R3 no recapture", int'(byte_count), exp_cnt);
            chk(cmd_ready == 1'b0, "R4 one cycle", int'(cmd_ready), 0);
        end
        host_syn = 1'b0;
        @(negedge clk);
        chk(host_ack == 1'b0, "R3 ack falls", int'(host_ack), 0);
        chk(cmd_ready == 1'b0, "R4 one cycle", int'(cmd_ready), 0);
    endtask

    task automatic check_buffer();
        chk(int'(byte_count) == exp_cnt, "R9 final count", int'(byte_count), exp_cnt);
        chk(overflow == exp_ovf, "R8 flag", int'(overflow), int'(exp_ovf));
        for (int i = 0; i < exp_cnt; i++)
            chk(buf_data[8*i +: 8] == exp_buf[i], "R9 content", int'(buf_data[8*i +: 8]), int'(exp_buf[i]));
    endtask

    task automatic hold_then_release(input int syn_cycles);
        host_data = 8'h11;
        host_syn  = (syn_cycles > 0);
        for (int k = 0; k < syn_cycles; k++) begin
            @(negedge clk);
            chk(host_ack == 1'b0, "R6 ignore syn", int'(host_ack), 0);
            chk(int'(byte_count) == exp_cnt, "R6 count kept", int'(byte_count), exp_cnt);
        end
        host_syn    = 1'b0;
        cmd_release = 1'b1;
        @(negedge clk);
        cmd_release = 1'b0;
        exp_cnt = 0;
        exp_ovf = 1'b0;
        chk(byte_count == '0, "R7 count cleared", int'(byte_count), 0);
        chk(overflow == 1'b0, "R7 overflow cleared", int'(overflow), 0);
    endtask

    task automatic send_msg(input int len, input int extra);
        send_byte(8'h55, extra);
        for (int i = 1; i < len - 1; i++) send_byte(rand_payload(), extra);
        send_byte(8'hAA, extra);
        check_buffer();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(host_ack == 1'b0, "R1 ack", int'(host_ack), 0);
        chk(byte_count == '0, "R1 count", int'(byte_count), 0);
        chk(overflow == 1'b0, "R1 overflow", int'(overflow), 0);
        chk(cmd_ready == 1'b0, "R1 ready", int'(cmd_ready), 0);

        // directed: read-sized message, SYN held long
        send_msg(5, 3);
        hold_then_release(4);

        // R10: release outside hold mid-message has no effect
        send_byte(8'h55, 0);
        send_byte(8'h10, 0);
        cmd_release = 1'b1;
        @(negedge clk);
        cmd_release = 1'b0;
        chk(int'(byte_count) == exp_cnt, "R10 release ignored", int'(byte_count), exp_cnt);
        send_byte(8'h55, 0);  // start value mid-message: plain data, R5
        send_byte(8'hAA, 0);
        check_buffer();
        hold_then_release(0);

        // R8: overlong message, ends after overflow
        for (int i = 0; i < DEPTH + 3; i++) send_byte(rand_payload(), 0);
        send_byte(8'hAA, 1);
        check_buffer();
        hold_then_release(2);
        send_byte(8'h77, 0);
        chk(buf_data[7:0] == 8'h77, "R7 slot0 after release", int'(buf_data[7:0]), 'h77);
        send_byte(8'hAA, 0);
        hold_then_release(0);

        // random messages of valid lengths
        for (int m = 0; m < 40; m++) begin
            int sel = $urandom_range(0, 2);
            int len = (sel == 0) ? 3 : (sel == 1) ? 5 : 9;
            send_msg(len, $urandom_range(0, 2));
            hold_then_release($urandom_range(0, 3));
        end

        // R1: reset mid-message
        send_byte(8'h55, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(byte_count == '0, "R1 reset count", int'(byte_count), 0);
        chk(host_ack == 1'b0, "R1 reset ack", int'(host_ack), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule